// File: doc/BRIEF.md
# IR Pulse Run-Length Sampler

This block watches one demodulated infrared receiver line and turns it into a stream of run-length bytes. The line is synchronized to the module clock. On every sample tick (typically the module clock divided by 64, so 8 us per sample at 8 MHz), the level is captured after an optional polarity flip. Each stretch of constant level becomes one byte. Bit 7 carries the level and bits 6:0 carry the length in samples minus one.

A noise filter rejects short level changes and folds their samples into the surrounding run. Runs longer than 128 samples are cut into 128-sample pieces. A space that lasts as long as the idle threshold closes the packet: the last space byte is emitted together with a packet-end strobe, and the block then waits silently for the next pulse. A downstream FIFO or decoder takes the bytes and the packet-end strobe. Typical settings are a noise threshold of 1 and an idle threshold of 20.

Top module: `ir_run_sampler`

## Requirements
- R1: An output byte has bit 7 = 1 for a pulse run and 0 for a space run, and bits 6:0 = run length in samples minus one. The byte is emitted when the run ends.
- R2: When `invert_i` is 1, the input is flipped before sampling. With `invert_i` = 0, `ir_i` = 1 is a pulse. With `invert_i` = 1, `ir_i` = 0 is a pulse.
- R3: A level change is accepted only after `noise_thr_i` + 1 consecutive samples at the new level. A change of `noise_thr_i` samples or fewer is ignored. A threshold of 0 accepts a one-sample change.
- R4: The samples of an ignored change count toward the duration of the run that it interrupted. This includes the space count used for packet end.
- R5: When a run reaches 128 samples, a byte with length field 127 is emitted and counting of the same level restarts at zero. A run that ends with zero samples after a split emits no further byte.
- R6: When the space run reaches `idle_thr_i` samples, its byte is emitted together with a one-cycle `pkt_end_o`, and the block returns to idle.
- R7: In idle, no byte is emitted. The first accepted pulse starts a run whose length counts from its first pulse sample.
- R8: An idle threshold of 0 disables packet-end detection.
- R9: The block samples and emits only while both `glb_en_i` and `rx_en_i` are 1. Clearing either one returns it to idle with all counts cleared.
- R10: The line is sampled only on cycles with `tick_i` = 1. Samples go through a two-flop synchronizer. `byte_vld_o` and `pkt_end_o` are one-cycle strobes, and they rise two clocks after the tick that caused them. Both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| ir_i | input | 1 | Raw receiver line, asynchronous |
| tick_i | input | 1 | Sample enable strobe |
| invert_i | input | 1 | Flip the line polarity |
| noise_thr_i | input | 6 | Longest ignored change, in samples |
| idle_thr_i | input | 8 | Space length that ends a packet, 0 = off |
| byte_vld_o | output | 1 | Run byte strobe |
| byte_o | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end_o | output | 1 | Packet-end strobe |

## Verification
The stimulus covers several kinds of input:
- Plain alternating pulse and space runs, which check the level bit and the minus-one length.
- A single-sample glitch inside a pulse and inside a space, which shows that the glitch is absorbed rather than cut into three runs, and that the idle count still includes it.
- A 300-sample pulse and an exact 128-sample pulse, which show the split and the zero-remainder case.
- Bursts that are shorter than a threshold of 3 and a threshold of 0, which separate rejection from acceptance.
- Inverted drive, disabled packet end, line activity without ticks, and activity while disabled or across a mid-run disable. In each of these cases the output must stay silent or carry no left-over count.

// File: rtl/ir_sampler_pkg.sv
package ir_sampler_pkg;
  localparam int unsigned LEN_W   = 7;
  localparam int unsigned RUN_MAX = 1 << LEN_W;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } trk_state_e;

  typedef struct packed {
    logic             pulse;
    logic [LEN_W-1:0] len_m1;
  } run_byte_t;
endpackage

// File: rtl/ir_input_stage.sv
module ir_input_stage #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ir_i,
  input  logic tick_i,
  input  logic invert_i,
  output logic smp_vld_o,
  output logic smp_lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   smp_vld_q, smp_lvl_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ir_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ir_i};
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_q <= 1'b0;
      smp_lvl_q <= 1'b0;
    end else begin
      smp_vld_q <= tick_i & en_i;
      if (tick_i) smp_lvl_q <= line_s ^ invert_i;
    end
  end

  assign smp_vld_o = smp_vld_q;
  assign smp_lvl_o = smp_lvl_q;
endmodule

// File: rtl/ir_run_tracker.sv
module ir_run_tracker
  import ir_sampler_pkg::*;
#(
  parameter int unsigned NOISE_W = 6,
  parameter int unsigned IDLE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              smp_vld_i,
  input  logic              smp_lvl_i,
  input  logic [NOISE_W-1:0] noise_thr_i,
  input  logic [IDLE_W-1:0] idle_thr_i,
  output logic              emit_vld_o,
  output run_byte_t         emit_byte_o,
  output logic              end_o
);
  localparam int unsigned CAND_W = NOISE_W + 1;
  localparam int unsigned CNT_W  = (LEN_W > CAND_W ? LEN_W : CAND_W) + 2;
  localparam int unsigned TOT_W  = IDLE_W;

  trk_state_e        state_q, state_d;
  logic              cur_q, cur_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, n_cnt;
  logic [CAND_W-1:0] cand_q, cand_d, cand_inc;
  logic [TOT_W-1:0]  tot_q, tot_d, n_tot;
  logic              cand_hit, changed;
  logic              ev_vld_q, ev_vld_d, end_q, end_d;
  run_byte_t         ev_byte_q, ev_byte_d;

  function automatic logic [TOT_W-1:0] sat_add(logic [TOT_W-1:0] a, logic [CAND_W-1:0] b);
    logic [TOT_W+CAND_W:0] s;
    s = (TOT_W+CAND_W+1)'(a) + (TOT_W+CAND_W+1)'(b);
    if (s > (TOT_W+CAND_W+1)'({TOT_W{1'b1}})) return '1;
    return s[TOT_W-1:0];
  endfunction

  assign cand_inc = cand_q + 1'b1;
  assign cand_hit = cand_inc > CAND_W'(noise_thr_i);

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    cnt_d     = cnt_q;
    cand_d    = cand_q;
    tot_d     = tot_q;
    ev_vld_d  = 1'b0;
    ev_byte_d = '0;
    end_d     = 1'b0;
    n_cnt     = cnt_q;
    n_tot     = tot_q;
    changed   = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      cur_d   = 1'b0;
      cnt_d   = '0;
      cand_d  = '0;
      tot_d   = '0;
    end else if (smp_vld_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (smp_lvl_i) begin
            if (cand_hit) begin
              state_d = ST_ACTIVE;
              cur_d   = 1'b1;
              cnt_d   = CNT_W'(cand_inc);
              tot_d   = '0;
              cand_d  = '0;
            end else begin
              cand_d = cand_inc;
            end
          end else begin
            cand_d = '0;
          end
        end
        default: begin
          if (smp_lvl_i != cur_q) begin
            if (cand_hit) begin
              changed          = 1'b1;
              ev_vld_d         = cnt_q != '0;
              ev_byte_d.pulse  = cur_q;
              ev_byte_d.len_m1 = LEN_W'(cnt_q - 1'b1);
              cur_d            = smp_lvl_i;
              cnt_d            = CNT_W'(cand_inc);
              cand_d           = '0;
              tot_d            = smp_lvl_i ? '0 : sat_add('0, cand_inc);
            end else begin
              cand_d = cand_inc;
            end
          end else begin
            // pending samples of a rejected change join the current run
            n_cnt  = cnt_q + CNT_W'(cand_inc);
            n_tot  = cur_q ? tot_q : sat_add(tot_q, cand_inc);
            cand_d = '0;
          end
          if (!changed) begin
            if (n_cnt >= CNT_W'(RUN_MAX)) begin
              ev_vld_d         = 1'b1;
              ev_byte_d.pulse  = cur_q;
              ev_byte_d.len_m1 = '1;
              cnt_d            = n_cnt - CNT_W'(RUN_MAX);
              tot_d            = n_tot;
            end else if (!cur_q && idle_thr_i != '0 && n_tot >= idle_thr_i) begin
              ev_vld_d         = n_cnt != '0;
              ev_byte_d.pulse  = 1'b0;
              ev_byte_d.len_m1 = LEN_W'(n_cnt - 1'b1);
              end_d            = 1'b1;
              state_d          = ST_IDLE;
              cur_d            = 1'b0;
              cnt_d            = '0;
              cand_d           = '0;
              tot_d            = '0;
            end else begin
              cnt_d = n_cnt;
              tot_d = n_tot;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_q     <= 1'b0;
      cnt_q     <= '0;
      cand_q    <= '0;
      tot_q     <= '0;
      ev_vld_q  <= 1'b0;
      ev_byte_q <= '0;
      end_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      cnt_q     <= cnt_d;
      cand_q    <= cand_d;
      tot_q     <= tot_d;
      ev_vld_q  <= ev_vld_d;
      ev_byte_q <= ev_byte_d;
      end_q     <= end_d;
    end
  end

  assign emit_vld_o  = ev_vld_q;
  assign emit_byte_o = ev_byte_q;
  assign end_o       = end_q;
endmodule

// File: rtl/ir_byte_port.sv
module ir_byte_port
  import ir_sampler_pkg::*;
(
  input  logic      emit_vld_i,
  input  run_byte_t emit_byte_i,
  input  logic      end_i,
  output logic      byte_vld_o,
  output logic [7:0] byte_o,
  output logic      pkt_end_o
);
  assign byte_vld_o = emit_vld_i;
  assign byte_o     = emit_vld_i ? 8'(emit_byte_i) : 8'h00;
  assign pkt_end_o  = end_i;
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
  import ir_sampler_pkg::*;
#(
  parameter int unsigned NOISE_W     = 6,
  parameter int unsigned IDLE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic               rx_en_i,
  input  logic               ir_i,
  input  logic               tick_i,
  input  logic               invert_i,
  input  logic [NOISE_W-1:0] noise_thr_i,
  input  logic [IDLE_W-1:0]  idle_thr_i,
  output logic               byte_vld_o,
  output logic [7:0]         byte_o,
  output logic               pkt_end_o
);
  logic      en;
  logic      smp_vld, smp_lvl;
  logic      emit_vld, emit_end;
  run_byte_t emit_byte;

  assign en = glb_en_i & rx_en_i;

  ir_input_stage #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk_i, .rst_ni, .en_i(en), .ir_i, .tick_i, .invert_i,
    .smp_vld_o(smp_vld), .smp_lvl_o(smp_lvl)
  );

  ir_run_tracker #(.NOISE_W(NOISE_W), .IDLE_W(IDLE_W)) u_trk (
    .clk_i, .rst_ni, .en_i(en), .smp_vld_i(smp_vld), .smp_lvl_i(smp_lvl),
    .noise_thr_i, .idle_thr_i,
    .emit_vld_o(emit_vld), .emit_byte_o(emit_byte), .end_o(emit_end)
  );

  ir_byte_port u_out (
    .emit_vld_i(emit_vld), .emit_byte_i(emit_byte), .end_i(emit_end),
    .byte_vld_o, .byte_o, .pkt_end_o
  );
endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk #(
  parameter int unsigned IDLE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glb_en_i,
  input logic              rx_en_i,
  input logic              tick_i,
  input logic [IDLE_W-1:0] idle_thr_i,
  input logic              byte_vld_o,
  input logic [7:0]        byte_o,
  input logic              pkt_end_o
);
  logic seen_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_end_q <= 1'b0;
    else if (!(glb_en_i && rx_en_i)) seen_end_q <= 1'b0;
    else if (pkt_end_o)               seen_end_q <= 1'b1;
    else if (byte_vld_o)              seen_end_q <= 1'b0;
  end

  a_r6_end_with_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_o && byte_vld_o) |-> !byte_o[7]);

  a_r6_end_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |=> !pkt_end_o);

  a_r7_pulse_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_end_q && byte_vld_o) |-> byte_o[7]);

  a_r8_end_needs_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> $past(idle_thr_i) != '0);

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glb_en_i && rx_en_i) |=> (!byte_vld_o && !pkt_end_o));

  a_r10_vld_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o || pkt_end_o) |-> $past(tick_i, 2));
endmodule

bind ir_run_sampler ir_run_sampler_chk #(.IDLE_W(IDLE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .rx_en_i(rx_en_i),
  .tick_i(tick_i), .idle_thr_i(idle_thr_i), .byte_vld_o(byte_vld_o),
  .byte_o(byte_o), .pkt_end_o(pkt_end_o)
);

// File: tb/ir_run_sampler_test.sv
module ir_run_sampler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en = 1'b0, rx_en = 1'b0, ir = 1'b0, tick = 1'b0, inv = 1'b0;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd20;
  logic       byte_vld, pkt_end;
  logic [7:0] byte_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] exp_q[$];   // {has_byte, end, byte}
  string      tag_q[$];

  always #10 clk = ~clk;

  ir_run_sampler uut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .rx_en_i(rx_en), .ir_i(ir),
    .tick_i(tick), .invert_i(inv), .noise_thr_i(noise_thr), .idle_thr_i(idle_thr),
    .byte_vld_o(byte_vld), .byte_o(byte_out), .pkt_end_o(pkt_end)
  );

  task automatic expect_b(input bit pulse, input int len, input bit e, input string tag);
    exp_q.push_back({1'b1, e, pulse, 7'(len - 1)});
    tag_q.push_back(tag);
  endtask

  task automatic expect_end_only(input string tag);
    exp_q.push_back({1'b0, 1'b1, 8'h00});
    tag_q.push_back(tag);
  endtask

  // one sample per call: line set, settle through synchronizer, single tick
  task automatic run(input bit pulse, input int n);
    for (int i = 0; i < n; i++) begin
      ir = pulse ^ inv;
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d bytes missing, actual none expected %03h",
               tag, exp_q.size(), exp_q[0]);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (byte_vld || pkt_end)) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected output: actual vld=%0b byte=%02h end=%0b expected none",
                 byte_vld, byte_out, pkt_end);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (byte_vld != e[9] || pkt_end != e[8] || (e[9] && byte_out != e[7:0])) begin
          fails++;
          $display("FAIL %s: actual vld=%0b byte=%02h end=%0b expected vld=%0b byte=%02h end=%0b",
                   t, byte_vld, byte_out, pkt_end, e[9], e[7:0], e[8]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (byte_vld !== 1'b0 || pkt_end !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual vld=%0b end=%0b expected 0 0", byte_vld, pkt_end);
    end
    rst_n = 1'b1;
    glb_en = 1'b1; rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R7/R6: basic runs, leading idle emits nothing
    expect_b(1, 10, 0, "R1 pulse 10");
    expect_b(0, 7,  0, "R1 space 7");
    expect_b(1, 3,  0, "R7 pulse 3");
    expect_b(0, 20, 1, "R6 packet end");
    run(0, 5); run(1, 10); run(0, 7); run(1, 3); run(0, 25);
    drain("R1 basic");

    // R4: glitch inside a pulse
    expect_b(1, 16, 0, "R4 pulse glitch absorbed");
    expect_b(0, 20, 1, "R6 end after glitch");
    run(1, 10); run(0, 1); run(1, 5); run(0, 25);
    drain("R4 pulse glitch");

    // R4: glitch inside a space counts toward idle
    expect_b(1, 4,  0, "R4 pulse 4");
    expect_b(0, 20, 1, "R4 idle count includes glitch");
    run(1, 4); run(0, 6); run(1, 1); run(0, 13);
    drain("R4 space glitch");
    run(0, 7);
    drain("R7 quiet after end");

    // R5: long pulse split
    expect_b(1, 128, 0, "R5 split 1");
    expect_b(1, 128, 0, "R5 split 2");
    expect_b(1, 44,  0, "R5 remainder");
    expect_b(0, 20,  1, "R6 end after split");
    run(1, 300); run(0, 25);
    drain("R5 long");

    // R5: exactly 128, no zero-length remainder
    expect_b(1, 128, 0, "R5 exact 128");
    expect_b(0, 20,  1, "R5 space after exact");
    run(1, 128); run(0, 25);
    drain("R5 exact");

    // R2: inverted polarity
    inv = 1'b1;
    run(0, 4);
    expect_b(1, 8,  0, "R2 inverted pulse");
    expect_b(0, 20, 1, "R2 inverted space");
    run(1, 8); run(0, 25);
    drain("R2 invert");
    inv = 1'b0;
    run(0, 3);

    // R3: threshold 0 accepts single samples
    noise_thr = 6'd0;
    expect_b(1, 1, 0, "R3 thr0 pulse");
    expect_b(0, 1, 0, "R3 thr0 space");
    expect_b(1, 1, 0, "R3 thr0 pulse b");
    expect_b(0, 20, 1, "R3 thr0 end");
    run(1, 1); run(0, 1); run(1, 1); run(0, 22);
    drain("R3 thr0");

    // R3: threshold 3 rejects a 3-sample burst from idle
    noise_thr = 6'd3;
    run(1, 3); run(0, 5);
    drain("R3 burst rejected");
    expect_b(1, 6,  0, "R3 thr3 pulse");
    expect_b(0, 20, 1, "R3 thr3 end");
    run(1, 6); run(0, 25);
    drain("R3 thr3");
    noise_thr = 6'd1;

    // R8: idle threshold 0 disables packet end
    idle_thr = 8'd0;
    expect_b(1, 5, 0, "R8 pulse");
    run(1, 5); run(0, 40);
    drain("R8 no end");
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    idle_thr = 8'd20;

    // R10: line activity without ticks is not sampled
    ir = 1'b1;
    repeat (40) @(negedge clk);
    ir = 1'b0;
    repeat (40) @(negedge clk);
    run(0, 25);
    drain("R10 no tick");

    // R9: global enable low blocks everything
    glb_en = 1'b0;
    run(1, 10); run(0, 25);
    drain("R9 disabled");
    glb_en = 1'b1;
    run(0, 3);

    // R9: clearing receive enable mid-run discards the count
    run(1, 10);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    run(0, 25);
    drain("R9 reset mid-run");
    expect_b(1, 3,  0, "R9 fresh pulse");
    expect_b(0, 20, 1, "R9 fresh end");
    run(1, 3); run(0, 25);
    drain("R9 after reenable");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule